// File: doc/BRIEF.md
# Register-Mapped Return Address Stack

This block is a bounded last-in-first-out store of return addresses that a small processor reaches through general-purpose register x1 instead of through dedicated stack instructions. Each instruction that writes x1 pushes its write data, and each instruction that reads x1 pops the top entry. The processor's decode stage presents, for one instruction per cycle, a push request with its data and one read request for each source operand slot that names x1. The block returns the top entry combinationally during that same cycle. The new stack state takes effect at the next rising clock edge.

One instruction may both read and write x1. In that case the top entry is overwritten and the depth stays the same. An instruction that names x1 in both source slots sees the same top value in both and pops only once. The block reports whether it is empty, partly filled or full. It raises a per-instruction overflow flag or underflow flag for an illegal request and leaves its contents alone in that case. Acting on those flags is left to the surrounding core. A synchronous clear empties the stack at the start of a new program run.

Top module: `ret_stack`

## Requirements
- R1: After synchronous reset the stack is empty: `empty_o`=1, `full_o`=0, `fill_o`=2'b00, and `rdata_o` reads 0.
- R2: A push with no pop on a stack that is not full raises the depth by one, and from the next cycle `rdata_o` shows the pushed data.
- R3: A pop with no push on a non-empty stack returns the top entry on `rdata_o` in the same cycle and lowers the depth by one, so that values come back in reverse push order.
- R4: A push and a pop in the same instruction on a non-empty stack return the old top, replace it with the write data, and keep the depth unchanged.
- R5: When both read slots request x1 in one instruction, both see the same `rdata_o` value and the depth drops by exactly one.
- R6: `fill_o` encodes the fullness state: 2'b00 when empty, 2'b01 when holding 1 to DEPTH-1 entries, and 2'b10 when holding DEPTH entries. `empty_o` and `full_o` are never high together.
- R7: A push without a pop while the stack holds DEPTH (default 8) entries raises `ovf_o` in that cycle and leaves depth and contents unchanged.
- R8: Any pop request on an empty stack, with or without a push, raises `unf_o` in that cycle and leaves the stack empty.
- R9: A push together with a pop on a full stack raises no overflow and replaces the top entry.
- R10: `clear_i` empties the stack at the next edge, overrides any request in the same cycle, and suppresses both error flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| clear_i | input | 1 | Synchronous clear at the start of a program run |
| push_i | input | 1 | Instruction writes x1 |
| wdata_i | input | WIDTH | Data to push |
| rd_a_i | input | 1 | First source slot reads x1 |
| rd_b_i | input | 1 | Second source slot reads x1 |
| rdata_o | output | WIDTH | Current top entry (0 when empty) |
| empty_o | output | 1 | Stack holds no entries |
| full_o | output | 1 | Stack holds DEPTH entries |
| fill_o | output | 2 | Fullness state: 00 empty, 01 partial, 10 full |
| ovf_o | output | 1 | Push refused on a full stack this cycle |
| unf_o | output | 1 | Pop refused on an empty stack this cycle |

## Verification
The bench targets five corner cases. A double read of x1 in one instruction would, in a design that popped once per read slot, lose an entry, and the depth seen afterwards would be wrong. Push-with-pop on a full stack would be flagged as overflow by a design that tested fullness before the pop, and push-with-pop on an empty stack would silently grow the stack if underflow were not given priority. After an overflow or underflow, the bench reads the whole stack back in order to catch a design that wrote the refused data or moved its pointer. Clear racing a request is exercised to show that clear wins and flags nothing.

// File: rtl/rstk_pkg.sv
package rstk_pkg;

    typedef enum logic [1:0] {
        FILL_EMPTY = 2'b00,
        FILL_PART  = 2'b01,
        FILL_FULL  = 2'b10
    } fill_e;

    typedef enum logic [1:0] {
        ACT_IDLE = 2'b00,
        ACT_PUSH = 2'b01,
        ACT_POP  = 2'b10,
        ACT_SWAP = 2'b11
    } act_e;

    typedef struct packed {
        act_e act;
        logic ovf;
        logic unf;
    } dec_t;

    function automatic fill_e fill_of(input logic empty, input logic full);
        if (empty)     return FILL_EMPTY;
        else if (full) return FILL_FULL;
        else           return FILL_PART;
    endfunction

endpackage

// File: rtl/rstk_ctrl.sv
module rstk_ctrl
    import rstk_pkg::*;
(
    input  logic clear_i,
    input  logic push_i,
    input  logic pop_i,
    input  logic empty_i,
    input  logic full_i,
    output dec_t dec_o
);

    // Underflow has priority over everything except clear; a paired
    // push/pop never overflows because the pop frees the slot first.
    always_comb begin
        dec_o = '{act: ACT_IDLE, ovf: 1'b0, unf: 1'b0};
        if (clear_i) begin
            dec_o.act = ACT_IDLE;
        end else if (pop_i && empty_i) begin
            dec_o.unf = 1'b1;
        end else if (push_i && pop_i) begin
            dec_o.act = ACT_SWAP;
        end else if (push_i && full_i) begin
            dec_o.ovf = 1'b1;
        end else if (push_i) begin
            dec_o.act = ACT_PUSH;
        end else if (pop_i) begin
            dec_o.act = ACT_POP;
        end
    end

endmodule

// File: rtl/rstk_mem.sv
module rstk_mem
    import rstk_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int WIDTH = 32
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             clear_i,
    input  act_e             act_i,
    input  logic [WIDTH-1:0] wdata_i,
    output logic [WIDTH-1:0] top_o,
    output logic             empty_o,
    output logic             full_o
);

    localparam int CW = $clog2(DEPTH + 1);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [CW-1:0]    count_q;
    logic [WIDTH-1:0] ent_q [DEPTH];
    logic [IW-1:0]    top_idx;
    logic [IW-1:0]    wr_idx;
    logic             wr_en;

    assign empty_o = (count_q == '0);
    assign full_o  = (count_q == CW'(DEPTH));
    assign top_idx = IW'(count_q - CW'(1));
    assign wr_idx  = (act_i == ACT_PUSH) ? IW'(count_q) : top_idx;
    assign wr_en   = (act_i == ACT_PUSH) || (act_i == ACT_SWAP);
    assign top_o   = empty_o ? '0 : ent_q[top_idx];

    always_ff @(posedge clk_i) begin
        if (rst_i || clear_i) begin
            count_q <= '0;
        end else begin
            case (act_i)
                ACT_PUSH: count_q <= count_q + CW'(1);
                ACT_POP:  count_q <= count_q - CW'(1);
                default:  count_q <= count_q;
            endcase
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                ent_q[g] <= '0;
            end else if (wr_en && !clear_i && (wr_idx == IW'(g))) begin
                ent_q[g] <= wdata_i;
            end
        end
    end

    // R2: a granted push grows the depth by exactly one
    p_push_grows_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (act_i == ACT_PUSH && !clear_i) |=> (count_q == $past(count_q) + CW'(1)));

    // R4: a swap keeps the depth
    p_swap_keeps_depth_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (act_i == ACT_SWAP && !clear_i) |=> $stable(count_q));

    // R6: depth never exceeds the bound
    p_depth_bound_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        count_q <= CW'(DEPTH));

    // R10: clear empties the store
    p_clear_empties_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        clear_i |=> empty_o);

endmodule

// File: rtl/ret_stack.sv
module ret_stack
    import rstk_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int WIDTH = 32
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             clear_i,
    input  logic             push_i,
    input  logic [WIDTH-1:0] wdata_i,
    input  logic             rd_a_i,
    input  logic             rd_b_i,
    output logic [WIDTH-1:0] rdata_o,
    output logic             empty_o,
    output logic             full_o,
    output logic [1:0]       fill_o,
    output logic             ovf_o,
    output logic             unf_o
);

    logic pop_req;
    dec_t dec;

    // Any number of x1 reads in one instruction is one pop.
    assign pop_req = rd_a_i | rd_b_i;

    rstk_ctrl u_ctrl (
        .clear_i (clear_i),
        .push_i  (push_i),
        .pop_i   (pop_req),
        .empty_i (empty_o),
        .full_i  (full_o),
        .dec_o   (dec)
    );

    rstk_mem #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_mem (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .clear_i (clear_i),
        .act_i   (dec.act),
        .wdata_i (wdata_i),
        .top_o   (rdata_o),
        .empty_o (empty_o),
        .full_o  (full_o)
    );

    assign fill_o = fill_of(empty_o, full_o);
    assign ovf_o  = dec.ovf;
    assign unf_o  = dec.unf;

    // R6: the two status bits are exclusive
    p_status_excl_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0({empty_o, full_o}));

    // R7: a refused push leaves the stack untouched
    p_no_overflow_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        ovf_o |=> (full_o && $stable(rdata_o)));

    // R8: a refused pop leaves the stack empty
    p_no_underflow_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        unf_o |=> empty_o);

    // R9: paired push and pop on a full stack is not an overflow
    p_full_swap_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        (full_o && push_i && pop_req) |-> !ovf_o);

    // R10: clear suppresses both error flags
    p_clear_quiet_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        clear_i |-> !(ovf_o || unf_o));

endmodule

// File: tb/ret_stack_test.sv
module ret_stack_test;

    localparam int W = 32;

    logic          clk = 1'b0;
    logic          rst, clear, push, rda, rdb;
    logic [W-1:0]  wd, rdata;
    logic          empty, full, ovf, unf;
    logic [1:0]    fill;
    int            n_run = 0, n_fail = 0;
    bit            done = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    ret_stack #(.DEPTH(8), .WIDTH(W)) uut (
        .clk_i(clk), .rst_i(rst), .clear_i(clear), .push_i(push),
        .wdata_i(wd), .rd_a_i(rda), .rd_b_i(rdb), .rdata_o(rdata),
        .empty_o(empty), .full_o(full), .fill_o(fill), .ovf_o(ovf), .unf_o(unf)
    );

    // push, rd_a, rd_b, wdata, exp_rdata, exp_ovf, exp_unf, exp_fill
    localparam int NV = 10;
    localparam logic [70:0] VEC [NV] = '{
        {3'b100, 32'h11, 32'h00, 1'b0, 1'b0, 2'b00},  // R2 push onto empty
        {3'b100, 32'h22, 32'h11, 1'b0, 1'b0, 2'b01},  // R2 second push
        {3'b010, 32'h00, 32'h22, 1'b0, 1'b0, 2'b01},  // R3 pop returns last
        {3'b011, 32'h00, 32'h11, 1'b0, 1'b0, 2'b01},  // R5 double read, one pop
        {3'b010, 32'h00, 32'h00, 1'b0, 1'b1, 2'b00},  // R8 pop on empty
        {3'b110, 32'h33, 32'h00, 1'b0, 1'b1, 2'b00},  // R8 push+pop on empty
        {3'b100, 32'h44, 32'h00, 1'b0, 1'b0, 2'b00},  // R2 push after underflows
        {3'b110, 32'h55, 32'h44, 1'b0, 1'b0, 2'b01},  // R4 swap top
        {3'b001, 32'h00, 32'h55, 1'b0, 1'b0, 2'b01},  // R4 swapped value, slot b
        {3'b000, 32'h00, 32'h00, 1'b0, 1'b0, 2'b00}   // R3 empty again
    };

    task automatic chk(input string tag, input logic [W-1:0] erd,
                       input logic eovf, input logic eunf, input logic [1:0] efill);
        n_run++;
        if (rdata !== erd || ovf !== eovf || unf !== eunf || fill !== efill ||
            empty !== (efill == 2'b00) || full !== (efill == 2'b10)) begin
            n_fail++;
            $display("FAIL %s: rd=%h ovf=%b unf=%b fill=%b empty=%b full=%b exp rd=%h ovf=%b unf=%b fill=%b",
                     tag, rdata, ovf, unf, fill, empty, full, erd, eovf, eunf, efill);
        end
    endtask

    // Drive after the falling edge, check before the rising edge, then step.
    task automatic step(input logic p, input logic a, input logic b,
                        input logic [W-1:0] d, input logic c);
        @(negedge clk);
        push = p; rda = a; rdb = b; wd = d; clear = c;
        #1;
    endtask

    task automatic idle();
        step(1'b0, 1'b0, 1'b0, '0, 1'b0);
    endtask

    initial begin
        rst = 1'b1; clear = 1'b0; push = 1'b0; rda = 1'b0; rdb = 1'b0; wd = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1 chk("R1 reset state", '0, 1'b0, 1'b0, 2'b00);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][70], VEC[i][69], VEC[i][68], VEC[i][67:36], 1'b0);
            chk($sformatf("vector %0d (R2/R3/R4/R5/R8)", i),
                VEC[i][35:4], VEC[i][3], VEC[i][2], VEC[i][1:0]);
        end

        // Fill to capacity; R6 partial state on the way
        for (int i = 0; i < 8; i++) begin
            step(1'b1, 1'b0, 1'b0, 32'h100 + i, 1'b0);
            if (i > 0) chk("R6 partial while filling", 32'h100 + i - 1, 1'b0, 1'b0, 2'b01);
        end
        idle();
        chk("R6 full state", 32'h107, 1'b0, 1'b0, 2'b10);

        step(1'b1, 1'b0, 1'b0, 32'h999, 1'b0);
        chk("R7 overflow flagged", 32'h107, 1'b1, 1'b0, 2'b10);
        idle();
        chk("R7 contents kept after overflow", 32'h107, 1'b0, 1'b0, 2'b10);

        step(1'b1, 1'b1, 1'b0, 32'h555, 1'b0);
        chk("R9 swap on full, no overflow", 32'h107, 1'b0, 1'b0, 2'b10);
        idle();
        chk("R9 top replaced", 32'h555, 1'b0, 1'b0, 2'b10);

        // Drain in reverse order: 555, 106 .. 100
        for (int i = 0; i < 8; i++) begin
            step(1'b0, 1'b1, 1'b1, '0, 1'b0);
            chk("R3 LIFO drain", (i == 0) ? 32'h555 : 32'h107 - i, 1'b0, 1'b0,
                (i == 0) ? 2'b10 : 2'b01);
        end
        idle();
        chk("R3 drained to empty", '0, 1'b0, 1'b0, 2'b00);

        // Clear overriding a request and suppressing errors
        step(1'b1, 1'b0, 1'b0, 32'hA1, 1'b0);
        step(1'b1, 1'b0, 1'b0, 32'hA2, 1'b0);
        step(1'b1, 1'b1, 1'b0, 32'hA3, 1'b1);
        chk("R10 clear with request", 32'hA2, 1'b0, 1'b0, 2'b01);
        idle();
        chk("R10 empty after clear", '0, 1'b0, 1'b0, 2'b00);
        step(1'b0, 1'b1, 1'b0, '0, 1'b1);
        chk("R10 clear masks underflow", '0, 1'b0, 1'b0, 2'b00);

        // Reset in mid-use
        step(1'b1, 1'b0, 1'b0, 32'h77, 1'b0);
        idle();
        chk("R2 push before reset", 32'h77, 1'b0, 1'b0, 2'b01);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        #1 chk("R1 reset empties", '0, 1'b0, 1'b0, 2'b00);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_run++; n_fail++;
                $display("FAIL watchdog: run did not complete, expected done");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule